// File: doc/BRIEF.md
# CAN Acceptance Filter Matcher

This block decides whether a CAN message that has just been assembled should be kept. It compares the frame against sixteen acceptance filters held in write-only configuration registers. Each filter picks one of four masks. A picked mask bit of 1 makes that bit significant. When the frame has a standard 11-bit identifier, the 18 low bits of each filter word are not needed for the identifier. They are then compared against the first data bits of the frame, over a programmable length. The result names the winning filter and the receive buffer linked to it. When nothing matches, the frame is to be dropped.

The message assembler raises `msg_done` for one cycle while the identifier, IDE flag, DLC and first three data bytes are presented. A small two-state machine captures the outcome:

- `ST_IDLE` is left on transition `T_CAPTURE` when a strobe arrives.
- `ST_REPORT` lasts one cycle. It stays in place on `T_AGAIN` when the next strobe comes at once.
- `ST_REPORT` returns on `T_RETIRE` when no strobe comes.
- `ST_IDLE` loops on `T_WAIT` when no strobe comes.

The result registers hold the last outcome until the next strobe.

Configuration map:

| Address | Content |
|---|---|
| 0 to 15 | Filter words |
| 16 | Mask A |
| 17 | Mask B |
| 18 | Enable bits |
| 19 | Mask-select codes |
| 20 | Control |
| 21 to 36 | Buffer links, one per filter |

Top module: `can_accept_match`

## Requirements
- R1: After reset `res_valid`, `res_hit`, `res_idx` and `res_buf` are 0, every filter is disabled, all masks and filter words are 0, and a frame sent before any configuration produces no hit.
- R2: A filter word at addresses 0..15 holds the identifier field in bits [28:0] and the expected IDE value in bit 29. A filter matches only if its IDE bit equals `msg_ide` and every bit set in its effective mask is equal between the filter field and the frame key. For extended frames the key is `msg_id[28:0]`.
- R3: The 2-bit mask-select code of filter i sits in bits [2i+1:2i] at address 19. Code 0 selects mask A (address 16, bits [28:0]). Code 1 selects mask B (address 17). Code 2 selects bits [28:0] of filter word 15. Code 3 selects a mask of all ones.
- R4: Control bit 0 at address 20 turns filter 15 into a mask. While it is set, filter 15 never reports a hit, even if enabled and equal to the frame. While it is clear, filter 15 behaves as an ordinary filter.
- R5: For standard frames (`msg_ide`=0) the key is the identifier `msg_id[10:0]` in bits [28:18], followed by the data bits in bits [17:0]. The data bits are taken MSB first from data byte 0 (`msg_data[23:16]`), then byte 1, then the top two bits of byte 2.
- R6: The data-filter length is control bits [12:8]. Only the first `len` data bits (key bits 17 down to 18-len) take part in the comparison. A length of 0 compares no data. Written values above 18 are stored as 18.
- R7: On a standard frame with nonzero length, a filter fails when the frame carries fewer than `len` data bits. The number of data bits is 8 times the DLC, and a DLC above 8 counts as 8.
- R8: Bit i at address 18 enables filter i. A disabled filter never hits.
- R9: When several filters match, the lowest-numbered one wins. `res_idx` is its number and `res_buf` is bits [3:0] of its link register at address 21+i.
- R10: `res_valid` is high in exactly the cycle after each `msg_done` cycle, back-to-back strobes included. The result outputs change only in that cycle and otherwise hold their value.
- R11: When no filter matches, `res_hit`, `res_idx` and `res_buf` are all 0 in the result cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| msg_done | input | 1 | One-cycle strobe: assembled message present |
| msg_id | input | 29 | Identifier (standard ID in bits [10:0]) |
| msg_ide | input | 1 | 1 for extended identifier frames |
| msg_dlc | input | 4 | Data length code |
| msg_data | input | 24 | Data bytes 0..2, byte 0 in bits [23:16] |
| res_valid | output | 1 | Result cycle marker |
| res_hit | output | 1 | A filter accepted the frame |
| res_idx | output | 4 | Number of the winning filter |
| res_buf | output | 4 | Buffer linked to the winning filter |

## Verification
The assertions assume that configuration is not rewritten while a frame is being evaluated. In particular, the check that a masked filter 15 stays silent and the check that only enabled filters win both compare a result against the settings of the strobe cycle. The stimulus therefore finishes every configuration write some cycles before it raises `msg_done` and never overlaps the two. Message fields are assumed stable only during the strobe cycle, and the bench changes them freely elsewhere.

// File: rtl/can_accept_pkg.sv
`timescale 1ns/1ps
package can_accept_pkg;
    localparam int ID_W      = 29;
    localparam int SID_W     = 11;
    localparam int DFILT_MAX = ID_W - SID_W;
    localparam int DLEN_W    = $clog2(DFILT_MAX + 1);
    localparam int DATA_W    = 24;

    typedef enum logic [1:0] {
        MSEL_A     = 2'd0,
        MSEL_B     = 2'd1,
        MSEL_F15   = 2'd2,
        MSEL_EXACT = 2'd3
    } msel_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } eval_st_e;

    typedef struct packed {
        logic            ide;
        logic [ID_W-1:0] id;
    } filt_t;
endpackage

// File: rtl/can_accept_regs.sv
`timescale 1ns/1ps
module can_accept_regs
    import can_accept_pkg::*;
#(
    parameter int NUM_FILT = 16,
    parameter int BUF_W    = 4,
    parameter int ADDR_W   = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [31:0]         cfg_wdata,
    output filt_t               filt  [NUM_FILT],
    output logic [ID_W-1:0]     mask_a,
    output logic [ID_W-1:0]     mask_b,
    output logic [NUM_FILT-1:0] en,
    output msel_e               sel   [NUM_FILT],
    output logic                f15_as_mask,
    output logic [DLEN_W-1:0]   dlen,
    output logic [BUF_W-1:0]    link  [NUM_FILT]
);
    localparam logic [ADDR_W-1:0] A_MASK_A = ADDR_W'(NUM_FILT);
    localparam logic [ADDR_W-1:0] A_MASK_B = ADDR_W'(NUM_FILT + 1);
    localparam logic [ADDR_W-1:0] A_EN     = ADDR_W'(NUM_FILT + 2);
    localparam logic [ADDR_W-1:0] A_SEL    = ADDR_W'(NUM_FILT + 3);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(NUM_FILT + 4);
    localparam int                A_LINK0  = NUM_FILT + 5;

    logic [DLEN_W-1:0] len_field;
    assign len_field = cfg_wdata[8 +: DLEN_W];

    for (genvar g = 0; g < NUM_FILT; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                filt[g] <= '0;
                link[g] <= '0;
                sel[g]  <= MSEL_A;
            end else if (cfg_we) begin
                if (cfg_addr == ADDR_W'(g))
                    filt[g] <= cfg_wdata[ID_W:0];
                if (cfg_addr == ADDR_W'(A_LINK0 + g))
                    link[g] <= cfg_wdata[BUF_W-1:0];
                if (cfg_addr == A_SEL)
                    sel[g] <= msel_e'(cfg_wdata[2*g +: 2]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_a      <= '0;
            mask_b      <= '0;
            en          <= '0;
            f15_as_mask <= 1'b0;
            dlen        <= '0;
        end else if (cfg_we) begin
            unique case (cfg_addr)
                A_MASK_A: mask_a <= cfg_wdata[ID_W-1:0];
                A_MASK_B: mask_b <= cfg_wdata[ID_W-1:0];
                A_EN:     en     <= cfg_wdata[NUM_FILT-1:0];
                A_CTRL: begin
                    f15_as_mask <= cfg_wdata[0];
                    dlen <= (32'(len_field) > DFILT_MAX) ? DLEN_W'(DFILT_MAX) : len_field;
                end
                default: ;
            endcase
        end
    end

    a_r6_len_capped: assert property (@(posedge clk) disable iff (!rst_n)
        32'(dlen) <= DFILT_MAX);

    a_r6_len_stored: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == A_CTRL && 32'(len_field) <= DFILT_MAX)
        |=> dlen == $past(len_field));
endmodule

// File: rtl/can_accept_cmp.sv
`timescale 1ns/1ps
module can_accept_cmp
    import can_accept_pkg::*;
#(
    parameter bit IS_LAST = 1'b0
) (
    input  filt_t                filt,
    input  msel_e                sel,
    input  logic [ID_W-1:0]      mask_a,
    input  logic [ID_W-1:0]      mask_b,
    input  logic [ID_W-1:0]      mask_alt,
    input  logic                 as_mask,
    input  logic                 enable,
    input  logic [ID_W-1:0]      key,
    input  logic                 ide,
    input  logic [DFILT_MAX-1:0] dmask,
    input  logic                 len_ok,
    output logic                 match
);
    logic [ID_W-1:0] msk;
    logic [ID_W-1:0] eff;

    always_comb begin
        unique case (sel)
            MSEL_A:   msk = mask_a;
            MSEL_B:   msk = mask_b;
            MSEL_F15: msk = mask_alt;
            default:  msk = '1;
        endcase
        eff   = ide ? msk : {msk[ID_W-1 -: SID_W], msk[DFILT_MAX-1:0] & dmask};
        match = enable && !(IS_LAST && as_mask) && (filt.ide == ide) && len_ok
                && (((key ^ filt.id) & eff) == '0);
    end
endmodule

// File: rtl/can_accept_prio.sv
`timescale 1ns/1ps
module can_accept_prio #(
    parameter  int NUM_FILT = 16,
    localparam int IDX_W    = $clog2(NUM_FILT)
) (
    input  logic [NUM_FILT-1:0] match,
    output logic                any,
    output logic [IDX_W-1:0]    idx
);
    always_comb begin
        any = |match;
        idx = '0;
        for (int i = NUM_FILT - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end

    always_comb begin
        if (!$isunknown(match) && any) begin
            a_r9_lowest_wins: assert (match[idx]
                && ((match & ((NUM_FILT'(1) << idx) - NUM_FILT'(1))) == '0));
        end
    end
endmodule

// File: rtl/can_accept_match.sv
`timescale 1ns/1ps
module can_accept_match
    import can_accept_pkg::*;
#(
    parameter  int NUM_FILT = 16,
    parameter  int BUF_W    = 4,
    parameter  int ADDR_W   = 6,
    localparam int IDX_W    = $clog2(NUM_FILT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [31:0]         cfg_wdata,
    input  logic                msg_done,
    input  logic [ID_W-1:0]     msg_id,
    input  logic                msg_ide,
    input  logic [3:0]          msg_dlc,
    input  logic [DATA_W-1:0]   msg_data,
    output logic                res_valid,
    output logic                res_hit,
    output logic [IDX_W-1:0]    res_idx,
    output logic [BUF_W-1:0]    res_buf
);
    filt_t                cfg_filt [NUM_FILT];
    logic [ID_W-1:0]      cfg_ma;
    logic [ID_W-1:0]      cfg_mb;
    logic [NUM_FILT-1:0]  cfg_en;
    msel_e                cfg_sel  [NUM_FILT];
    logic                 cfg_f15;
    logic [DLEN_W-1:0]    cfg_len;
    logic [BUF_W-1:0]     cfg_link [NUM_FILT];

    can_accept_regs #(.NUM_FILT(NUM_FILT), .BUF_W(BUF_W), .ADDR_W(ADDR_W)) u_regs (
        .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata,
        .filt(cfg_filt), .mask_a(cfg_ma), .mask_b(cfg_mb), .en(cfg_en),
        .sel(cfg_sel), .f15_as_mask(cfg_f15), .dlen(cfg_len), .link(cfg_link)
    );

    logic [ID_W-1:0]      key;
    logic [DFILT_MAX-1:0] dmask;
    logic                 len_ok;
    logic [3:0]           dlc_eff;
    logic [6:0]           avail_bits;

    always_comb begin
        dlc_eff    = (msg_dlc > 4'd8) ? 4'd8 : msg_dlc;
        avail_bits = {dlc_eff, 3'b000};
        dmask      = ~({DFILT_MAX{1'b1}} >> cfg_len);
        key        = msg_ide ? msg_id
                             : {msg_id[SID_W-1:0], msg_data[DATA_W-1 -: DFILT_MAX]};
        len_ok     = msg_ide || ({2'b00, cfg_len} <= avail_bits);
    end

    logic [NUM_FILT-1:0] match;

    for (genvar g = 0; g < NUM_FILT; g++) begin : g_cmp
        can_accept_cmp #(.IS_LAST(g == NUM_FILT - 1)) u_cmp (
            .filt(cfg_filt[g]), .sel(cfg_sel[g]),
            .mask_a(cfg_ma), .mask_b(cfg_mb), .mask_alt(cfg_filt[NUM_FILT-1].id),
            .as_mask(cfg_f15), .enable(cfg_en[g]),
            .key, .ide(msg_ide), .dmask, .len_ok,
            .match(match[g])
        );
    end

    logic             any;
    logic [IDX_W-1:0] pidx;

    can_accept_prio #(.NUM_FILT(NUM_FILT)) u_prio (
        .match, .any, .idx(pidx)
    );

    eval_st_e state, state_nxt;

    always_comb begin
        unique case (state)
            ST_IDLE:   state_nxt = msg_done ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_nxt = msg_done ? ST_REPORT : ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    assign res_valid = (state == ST_REPORT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_hit <= 1'b0;
            res_idx <= '0;
            res_buf <= '0;
        end else if (msg_done) begin
            res_hit <= any;
            res_idx <= any ? pidx : '0;
            res_buf <= any ? cfg_link[pidx] : '0;
        end
    end

    a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        msg_done |=> res_valid);

    a_r10_valid_only_after: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(msg_done));

    a_r10_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_done |=> ($stable(res_hit) && $stable(res_idx) && $stable(res_buf)));

    a_r4_f15_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_done && cfg_f15) |=> !(res_hit && res_idx == IDX_W'(NUM_FILT - 1)));

    a_r11_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_idx == '0 && res_buf == '0));

    a_r8_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit) |-> |(($past(cfg_en) >> res_idx) & NUM_FILT'(1)));
endmodule

// File: tb/can_accept_match_test.sv
`timescale 1ns/1ps
module can_accept_match_test;
    localparam int NF = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        msg_done = 1'b0;
    logic [28:0] msg_id = '0;
    logic        msg_ide = 1'b0;
    logic [3:0]  msg_dlc = '0;
    logic [23:0] msg_data = '0;
    logic        res_valid, res_hit;
    logic [3:0]  res_idx, res_buf;

    always #2.5 clk = ~clk;

    can_accept_match uut (
        .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata,
        .msg_done, .msg_id, .msg_ide, .msg_dlc, .msg_data,
        .res_valid, .res_hit, .res_idx, .res_buf
    );

    int n_chk = 0;
    int n_fail = 0;

    bit [29:0] b_filt [NF];
    bit [28:0] b_ma, b_mb;
    bit [15:0] b_en;
    bit [1:0]  b_sel [NF];
    bit        b_f15;
    int        b_len;
    bit [3:0]  b_link [NF];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 6'(addr); cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_filt(input int i, input bit ide, input bit [28:0] id);
        b_filt[i] = {ide, id};
        wr(i, {2'b00, ide, id});
    endtask

    task automatic set_mask(input int k, input bit [28:0] m);
        if (k == 0) b_ma = m; else b_mb = m;
        wr(NF + k, {3'b000, m});
    endtask

    task automatic set_en(input bit [15:0] e);
        b_en = e;
        wr(NF + 2, {16'h0, e});
    endtask

    task automatic set_sel(input int i, input bit [1:0] code);
        logic [31:0] w;
        b_sel[i] = code;
        w = '0;
        for (int k = 0; k < NF; k++) w[2*k +: 2] = b_sel[k];
        wr(NF + 3, w);
    endtask

    task automatic set_ctrl(input bit f15, input int len);
        b_f15 = f15;
        b_len = len;
        wr(NF + 4, {19'h0, 5'(len), 7'h0, f15});
    endtask

    task automatic set_link(input int i, input bit [3:0] b);
        b_link[i] = b;
        wr(NF + 5 + i, {28'h0, b});
    endtask

    // behavioural reference: walk the filters and bits one at a time
    task automatic model(input bit [28:0] id, input bit ide, input bit [3:0] dlc,
                         input bit [23:0] data, output bit h, output int wi, output int wb);
        bit [28:0] m;
        bit ok;
        int len, nbits, dbit;
        h = 1'b0; wi = 0; wb = 0;
        len   = (b_len > 18) ? 18 : b_len;
        nbits = ((dlc > 8) ? 8 : int'(dlc)) * 8;
        for (int i = 0; i < NF; i++) begin
            if (h) continue;
            if (!b_en[i]) continue;
            if (i == NF - 1 && b_f15) continue;
            if (b_filt[i][29] != ide) continue;
            case (b_sel[i])
                2'd0: m = b_ma;
                2'd1: m = b_mb;
                2'd2: m = b_filt[NF-1][28:0];
                default: m = '1;
            endcase
            ok = 1'b1;
            if (ide) begin
                for (int b = 0; b < 29; b++)
                    if (m[b] && b_filt[i][b] != id[b]) ok = 1'b0;
            end else begin
                for (int b = 0; b < 11; b++)
                    if (m[18+b] && b_filt[i][18+b] != id[b]) ok = 1'b0;
                if (len > nbits) ok = 1'b0;
                for (int k = 0; k < len; k++) begin
                    dbit = data[23 - k];
                    if (m[17-k] && b_filt[i][17-k] != dbit[0]) ok = 1'b0;
                end
            end
            if (ok) begin
                h = 1'b1; wi = i; wb = b_link[i];
            end
        end
    endtask

    task automatic send(input string req, input bit [28:0] id, input bit ide,
                        input bit [3:0] dlc, input bit [23:0] data);
        bit eh; int ei, eb;
        model(id, ide, dlc, data, eh, ei, eb);
        @(negedge clk);
        msg_done = 1'b1; msg_id = id; msg_ide = ide; msg_dlc = dlc; msg_data = data;
        @(negedge clk);
        msg_done = 1'b0; msg_id = ~id; msg_data = ~data;
        chk({req, " R10 valid"}, 32'(res_valid), 1);
        chk({req, " hit"}, 32'(res_hit), 32'(eh));
        chk({req, " idx"}, 32'(res_idx), ei);
        chk({req, " buf"}, 32'(res_buf), eb);
        @(negedge clk);
        chk("R10 valid drops", 32'(res_valid), 0);
        chk("R10 result held", {res_hit, res_idx, res_buf}, {eh, 4'(ei), 4'(eb)});
    endtask

    task automatic send_pair(input bit [28:0] id1, input bit [28:0] id2);
        bit h1, h2; int i1, i2, c1, c2;
        model(id1, 1'b1, 4'd8, 24'h0, h1, i1, c1);
        model(id2, 1'b1, 4'd8, 24'h0, h2, i2, c2);
        @(negedge clk);
        msg_done = 1'b1; msg_id = id1; msg_ide = 1'b1; msg_dlc = 4'd8; msg_data = '0;
        @(negedge clk);
        msg_id = id2;
        chk("R10 pair first valid", 32'(res_valid), 1);
        chk("R10 pair first result", {res_hit, res_idx}, {h1, 4'(i1)});
        @(negedge clk);
        msg_done = 1'b0;
        chk("R10 pair second valid", 32'(res_valid), 1);
        chk("R10 pair second result", {res_hit, res_idx, res_buf}, {h2, 4'(i2), 4'(c2)});
        @(negedge clk);
        chk("R10 pair valid drops", 32'(res_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        b_ma = '0; b_mb = '0; b_en = '0; b_f15 = 1'b0; b_len = 0;
        for (int i = 0; i < NF; i++) begin
            b_filt[i] = '0; b_sel[i] = '0; b_link[i] = '0;
        end
        repeat (3) @(negedge clk);
        chk("R1 reset valid", 32'(res_valid), 0);
        chk("R1 reset outputs", {res_hit, res_idx, res_buf}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after release", 32'(res_valid), 0);
        send("R1 R8 unconfigured", 29'h0, 1'b1, 4'd0, 24'h0);
        send("R1 R8 unconfigured std", 29'h0, 1'b0, 4'd0, 24'h0);

        // R2: masked extended match and IDE equality
        set_filt(0, 1'b1, 29'h1234567);
        set_mask(0, 29'h1FFFFFF0);
        set_link(0, 4'd9);
        send("R8 disabled filter", 29'h1234567, 1'b1, 4'd8, 24'h0);
        set_en(16'h0001);
        send("R2 exact ext", 29'h1234567, 1'b1, 4'd8, 24'h0);
        send("R2 masked-off bits", 29'h123456A, 1'b1, 4'd8, 24'h0);
        send("R2 R11 significant bit differs", 29'h1234577, 1'b1, 4'd8, 24'h0);
        send("R2 IDE differs", 29'h1234567, 1'b0, 4'd8, 24'h0);

        // R3: mask select codes
        set_filt(1, 1'b1, 29'h0000ABC);
        set_mask(1, 29'h1FFFF000);
        set_sel(1, 2'd1);
        set_link(1, 4'd3);
        set_filt(2, 1'b1, 29'h00000FF);
        set_sel(2, 2'd3);
        set_link(2, 4'd7);
        set_filt(3, 1'b1, 29'h1555555);
        set_sel(3, 2'd2);
        set_link(3, 4'd12);
        set_filt(15, 1'b1, 29'h1FFFFF00);
        set_link(15, 4'd15);
        set_ctrl(1'b1, 0);
        set_en(16'h800F);
        send("R3 mask B", 29'h0000123, 1'b1, 4'd8, 24'h0);
        send("R3 exact code", 29'h00000FF, 1'b1, 4'd8, 24'h0);
        send("R3 exact code miss", 29'h00000FE, 1'b1, 4'd8, 24'h0);
        send("R3 filter15 as mask", 29'h1555599, 1'b1, 4'd8, 24'h0);
        send("R4 masked filter15 silent", 29'h1FFFFF00, 1'b1, 4'd8, 24'h0);
        set_ctrl(1'b0, 0);
        send("R4 filter15 ordinary", 29'h1FFFFF00, 1'b1, 4'd8, 24'h0);

        // R5, R6, R7: standard frames with data filter
        set_filt(4, 1'b0, {11'h123, 8'hA5, 8'h3C, 2'b11});
        set_sel(4, 2'd3);
        set_link(4, 4'd4);
        set_en(16'h0010);
        set_ctrl(1'b0, 12);
        send("R5 R6 len12 match", 29'h123, 1'b0, 4'd8, 24'hA53F00);
        send("R6 len12 bit11 differs", 29'h123, 1'b0, 4'd8, 24'hA52C00);
        send("R5 SID differs", 29'h124, 1'b0, 4'd8, 24'hA53C00);
        set_ctrl(1'b0, 11);
        send("R6 len11 bit11 ignored", 29'h123, 1'b0, 4'd8, 24'hA52C00);
        set_ctrl(1'b0, 0);
        send("R6 len0 data ignored", 29'h123, 1'b0, 4'd0, 24'h000000);
        set_ctrl(1'b0, 18);
        send("R5 len18 full", 29'h123, 1'b0, 4'd3, 24'hA53CC0);
        send("R5 len18 last bit", 29'h123, 1'b0, 4'd3, 24'hA53C80);
        set_ctrl(1'b0, 25);
        send("R6 R7 len clamp dlc3", 29'h123, 1'b0, 4'd3, 24'hA53CC0);
        set_ctrl(1'b0, 12);
        send("R7 dlc1 short", 29'h123, 1'b0, 4'd1, 24'hA53C00);
        send("R7 dlc2 enough", 29'h123, 1'b0, 4'd2, 24'hA53C00);
        set_ctrl(1'b0, 18);
        send("R7 dlc15 counts 8", 29'h123, 1'b0, 4'd15, 24'hA53CC0);

        // R9: priority and buffer link
        set_filt(5, 1'b0, {11'h055, 18'h0});
        set_filt(6, 1'b0, {11'h055, 18'h0});
        set_sel(5, 2'd3);
        set_sel(6, 2'd3);
        set_link(5, 4'hA);
        set_link(6, 4'hB);
        set_ctrl(1'b0, 0);
        set_en(16'h0060);
        send("R9 lowest wins", 29'h055, 1'b0, 4'd0, 24'h0);
        set_en(16'h0040);
        send("R9 R8 next after disable", 29'h055, 1'b0, 4'd0, 24'h0);

        // R10: back-to-back strobes
        set_en(16'h8007);
        send_pair(29'h00000FF, 29'h1234560);

        // randomised configurations against the reference
        for (int r = 0; r < 12; r++) begin
            for (int i = 0; i < NF; i++) begin
                if ($urandom_range(0, 1) == 1)
                    set_filt(i, 1'b1, 29'($urandom_range(0, 15)));
                else
                    set_filt(i, 1'b0, {11'($urandom_range(0, 3)), 8'($urandom_range(0, 3)),
                                       10'($urandom)});
                set_link(i, 4'($urandom));
                b_sel[i] = 2'($urandom);
            end
            set_sel(0, b_sel[0]);
            set_mask(0, 29'h1FFFFFFF & ~29'($urandom_range(0, 15)));
            set_mask(1, 29'($urandom));
            set_en(16'($urandom));
            set_ctrl(1'($urandom), $urandom_range(0, 20));
            for (int f = 0; f < 16; f++) begin
                if ($urandom_range(0, 1) == 1)
                    send("R9 random ext", 29'($urandom_range(0, 15)), 1'b1,
                         4'($urandom), 24'($urandom));
                else
                    send("R9 random std", 29'($urandom_range(0, 3)), 1'b0,
                         4'($urandom), {8'($urandom_range(0, 3)), 16'($urandom)});
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule